// File: doc/BRIEF.md
# Four-Channel Serial Converter Register Front End

This block is the digital side of a four-channel, 8-bit converter. A host sends 11-bit command words over three wires: a serial clock, a data line and a load line. Each word names one channel, gives that channel an output span setting, and carries an 8-bit code. The block samples all serial lines in its own system clock domain. It keeps two latches for every channel. An input latch takes the word when the load line falls. An output latch drives the converter.

A fourth input, an active-low update strobe, decides when the output latches move. If the strobe is low when a word is loaded, the addressed channel's output follows at once. If the strobe is high, new words wait in the input latches. A falling edge of the strobe then copies all four input latches to the outputs together. The outputs are four 8-bit codes and four span flags, which feed resistor-string converters outside this block.

Top module: `quad_dac_front`

## Requirements
- R1: A command word is the last 11 bits shifted before the load line falls. They arrive in this order: channel address bit 1, address bit 0, the span bit, then code bits 7 down to 0. Bits shifted earlier are discarded.
- R2: A bit is shifted only on a falling edge of the serial clock while the load line is high. Serial clock edges that occur while the load line is low do not change the shifted word.
- R3: Address 00 selects channel 0, 01 selects channel 1, 10 selects channel 2 and 11 selects channel 3. Channel n is bits [8n+7:8n] of outCode and bit n of outRange.
- R4: A falling edge of the load line writes the word into the addressed channel's input latch only. All other channels keep their contents.
- R5: If updN is low when the load line falls, the addressed channel's output code and span flag take the new word.
- R6: If updN is high when the load line falls, the outputs do not change. A later high-to-low transition of updN copies all four input latches to the outputs.
- R7: While rstN is low, every output code, span flag, input latch and the shift register are cleared to zero.
- R8: The span bit (0 for 1x, 1 for 2x) travels with the code into the addressed channel's latches and appears on outRange.
- R9: An output change caused by a load or updN edge appears after the third rising system clock edge that follows the input transition. After the second edge the output still holds its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serClk | input | 1 | Serial clock; data is taken on its falling edge |
| serData | input | 1 | Serial data line |
| serLoad | input | 1 | Load line; high while shifting, a falling edge loads the word |
| updN | input | 1 | Active-low simultaneous update strobe |
| outCode | output | 32 (4 x 8) | Output latch codes, channel n in bits [8n+7:8n] |
| outRange | output | 4 | Output latch span flags, bit n for channel n |

## Verification
Every serial line goes through two synchronizer flops. A third flop detects the edge, and a fourth register is the latch itself. So a load or update result is due after the third rising edge after the line moves. One dedicated check samples the output after the second edge, where it must still be old, and after the third edge, where it must be new. The driver holds each serial clock phase for three system cycles. It pushes an expected snapshot of all four channels only after it has waited at least four cycles past its last strobe edge. The monitor compares that snapshot on a falling clock edge, so it sees only settled outputs.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  // Strobes from control to datapath, one system cycle wide each
  typedef struct packed {
    logic shiftEn;     // shift one serial bit into the word register
    logic frameLoad;   // load line fell: capture the word
    logic xferAll;     // update strobe fell: copy all input latches
    logic transparent; // update strobe currently low
  } dacfe_strobe_t;

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/dacfe_ctrl.sv
module dacfe_ctrl
  import dacfe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          serClk,
  input  logic          serData,
  input  logic          serLoad,
  input  logic          updN,
  output dacfe_strobe_t strobe,
  output logic          dataBit
);

  localparam int NUM_LINES = 4;
  localparam int IDX_SCLK  = 0;
  localparam int IDX_DATA  = 1;
  localparam int IDX_LOAD  = 2;
  localparam int IDX_UPD   = 3;
  // Idle levels: serial clock, load and update high, data low
  localparam logic [NUM_LINES-1:0] IDLE_LVL = 4'b1101;

  logic [NUM_LINES-1:0] rawLines;
  logic [NUM_LINES-1:0] syncLines;
  logic prevSclk, prevLoad, prevUpd;

  assign rawLines = {updN, serLoad, serData, serClk};

  dacfe_sync #(
    .W(NUM_LINES),
    .STAGES(SYNC_STAGES),
    .RST_VAL(IDLE_LVL)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (rawLines),
    .dout(syncLines)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSclk <= IDLE_LVL[IDX_SCLK];
      prevLoad <= IDLE_LVL[IDX_LOAD];
      prevUpd  <= IDLE_LVL[IDX_UPD];
    end else begin
      prevSclk <= syncLines[IDX_SCLK];
      prevLoad <= syncLines[IDX_LOAD];
      prevUpd  <= syncLines[IDX_UPD];
    end
  end

  always_comb begin
    strobe.shiftEn     = prevSclk & ~syncLines[IDX_SCLK] & syncLines[IDX_LOAD];
    strobe.frameLoad   = prevLoad & ~syncLines[IDX_LOAD];
    strobe.xferAll     = prevUpd & ~syncLines[IDX_UPD];
    strobe.transparent = ~syncLines[IDX_UPD];
  end

  assign dataBit = syncLines[IDX_DATA];

endmodule

// File: rtl/dacfe_datapath.sv
module dacfe_datapath
  import dacfe_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 8,
  localparam int ADDR_W = $clog2(NUM_CH),
  localparam int WORD_W = ADDR_W + 1 + CODE_W
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dacfe_strobe_t                  strobe,
  input  logic                           dataBit,
  output logic [NUM_CH-1:0][CODE_W-1:0]  outCode,
  output logic [NUM_CH-1:0]              outRange,
  output logic [NUM_CH-1:0][CODE_W-1:0]  inCode,
  output logic [NUM_CH-1:0]              inRange,
  output logic [ADDR_W-1:0]              wordAddr,
  output logic [CODE_W-1:0]              wordCode,
  output logic                           wordRange
);

  logic [WORD_W-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else if (strobe.shiftEn) shReg <= {shReg[WORD_W-2:0], dataBit};
  end

  assign wordAddr  = shReg[WORD_W-1 -: ADDR_W];
  assign wordRange = shReg[CODE_W];
  assign wordCode  = shReg[CODE_W-1:0];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic hit;
    assign hit = strobe.frameLoad && (wordAddr == ADDR_W'(ch));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inCode[ch]  <= '0;
        inRange[ch] <= 1'b0;
      end else if (hit) begin
        inCode[ch]  <= wordCode;
        inRange[ch] <= wordRange;
      end
    end

    // A word arriving in transparent mode wins over the bulk copy
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outCode[ch]  <= '0;
        outRange[ch] <= 1'b0;
      end else if (hit && strobe.transparent) begin
        outCode[ch]  <= wordCode;
        outRange[ch] <= wordRange;
      end else if (strobe.xferAll) begin
        outCode[ch]  <= inCode[ch];
        outRange[ch] <= inRange[ch];
      end
    end
  end

endmodule

// File: rtl/quad_dac_front.sv
module quad_dac_front
  import dacfe_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          serClk,
  input  logic                          serData,
  input  logic                          serLoad,
  input  logic                          updN,
  output logic [NUM_CH-1:0][CODE_W-1:0] outCode,
  output logic [NUM_CH-1:0]             outRange
);

  localparam int ADDR_W = $clog2(NUM_CH);

  dacfe_strobe_t                 strobe;
  logic                          dataBit;
  logic [NUM_CH-1:0][CODE_W-1:0] inCode;
  logic [NUM_CH-1:0]             inRange;
  logic [ADDR_W-1:0]             wordAddr;
  logic [CODE_W-1:0]             wordCode;
  logic                          wordRange;

  dacfe_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .serClk (serClk),
    .serData(serData),
    .serLoad(serLoad),
    .updN   (updN),
    .strobe (strobe),
    .dataBit(dataBit)
  );

  dacfe_datapath #(
    .NUM_CH(NUM_CH),
    .CODE_W(CODE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dataBit  (dataBit),
    .outCode  (outCode),
    .outRange (outRange),
    .inCode   (inCode),
    .inRange  (inRange),
    .wordAddr (wordAddr),
    .wordCode (wordCode),
    .wordRange(wordRange)
  );

endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk
  import dacfe_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 8,
  localparam int ADDR_W = $clog2(NUM_CH)
) (
  input logic                          clk,
  input logic                          rstN,
  input dacfe_strobe_t                 strobe,
  input logic [NUM_CH-1:0][CODE_W-1:0] outCode,
  input logic [NUM_CH-1:0]             outRange,
  input logic [NUM_CH-1:0][CODE_W-1:0] inCode,
  input logic [NUM_CH-1:0]             inRange,
  input logic [ADDR_W-1:0]             wordAddr,
  input logic [CODE_W-1:0]             wordCode,
  input logic                          wordRange
);

  // R6
  outputs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.frameLoad && !strobe.xferAll) |=> ($stable(outCode) && $stable(outRange)));

  // R6
  bulk_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.xferAll && !strobe.frameLoad) |=>
      (outCode == $past(inCode) && outRange == $past(inRange)));

  // R5
  transparent_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameLoad && strobe.transparent) |=> (outCode[$past(wordAddr)] == $past(wordCode)));

  // R8
  transparent_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameLoad && strobe.transparent) |=> (outRange[$past(wordAddr)] == $past(wordRange)));

  // R4
  input_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameLoad |=> (inCode[$past(wordAddr)] == $past(wordCode)));

  // R6
  held_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameLoad && !strobe.transparent && !strobe.xferAll) |=>
      ($stable(outCode) && $stable(outRange)));

endmodule

bind quad_dac_front dacfe_chk #(
  .NUM_CH(NUM_CH),
  .CODE_W(CODE_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .strobe   (strobe),
  .outCode  (outCode),
  .outRange (outRange),
  .inCode   (inCode),
  .inRange  (inRange),
  .wordAddr (wordAddr),
  .wordCode (wordCode),
  .wordRange(wordRange)
);

// File: tb/test_quad_dac_front.sv
module test_quad_dac_front;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b1;
  logic serData = 1'b0;
  logic serLoad = 1'b1;
  logic updN = 1'b1;
  logic [3:0][7:0] outCode;
  logic [3:0] outRange;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic [35:0] val;
    string       req;
  } exp_t;

  exp_t expQ[$];

  // Reference model state
  logic [3:0][7:0] mInCode, mOutCode;
  logic [3:0] mInRange, mOutRange;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_dac_front i_quad_dac_front (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLoad(serLoad), .updN(updN), .outCode(outCode), .outRange(outRange)
  );

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic modelReset();
    mInCode = '0; mOutCode = '0; mInRange = '0; mOutRange = '0;
  endtask

  task automatic expectNow(input string req);
    exp_t e;
    e.val = {mOutRange, mOutCode};
    e.req = req;
    expQ.push_back(e);
    tick(2);
  endtask

  task automatic shiftBit(input logic b);
    serData = b; tick(3);
    serClk = 1'b0; tick(3);
    serClk = 1'b1; tick(3);
  endtask

  task automatic sendWord(input logic [1:0] addr, input logic rng, input logic [7:0] code);
    logic [10:0] w;
    w = {addr, rng, code};
    for (int i = 10; i >= 0; i--) shiftBit(w[i]);
  endtask

  task automatic modelLoad(input logic [1:0] addr, input logic rng, input logic [7:0] code);
    mInCode[addr] = code; mInRange[addr] = rng;
    if (!updN) begin mOutCode[addr] = code; mOutRange[addr] = rng; end
  endtask

  task automatic pulseLoad(input logic [1:0] addr, input logic rng, input logic [7:0] code);
    serLoad = 1'b0; tick(4);
    serLoad = 1'b1; tick(4);
    modelLoad(addr, rng, code);
  endtask

  task automatic setUpd(input logic v);
    if (updN && !v) begin mOutCode = mInCode; mOutRange = mInRange; end
    updN = v; tick(5);
  endtask

  // Monitor: compares queued expectations against settled outputs
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        check({outRange, outCode} === e.val, e.req, {outRange, outCode}, e.val);
      end
    end
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    modelReset();
    tick(3);
    // R7 reset state
    check({outRange, outCode} === 36'h0, "R7 reset", {outRange, outCode}, 36'h0);
    rstN = 1'b1; tick(3);

    // Transparent loads to every address
    setUpd(1'b0);
    sendWord(2'b00, 1'b0, 8'hA5); pulseLoad(2'b00, 1'b0, 8'hA5); expectNow("R3 R5 ch0");
    sendWord(2'b01, 1'b1, 8'h3C); pulseLoad(2'b01, 1'b1, 8'h3C); expectNow("R8 ch1 2x span");
    sendWord(2'b10, 1'b0, 8'hFF); pulseLoad(2'b10, 1'b0, 8'hFF); expectNow("R3 ch2");
    sendWord(2'b11, 1'b1, 8'h01); pulseLoad(2'b11, 1'b1, 8'h01); expectNow("R4 ch3 others kept");

    // R9 latency of a transparent load
    sendWord(2'b10, 1'b1, 8'h5A);
    serLoad = 1'b0;
    tick(2);
    check(outCode[2] === 8'hFF, "R9 old after two edges", {28'h0, outCode[2]}, {28'h0, 8'hFF});
    tick(1);
    check(outCode[2] === 8'h5A && outRange[2] === 1'b1, "R9 new after three edges",
          {27'h0, outRange[2], outCode[2]}, {27'h0, 1'b1, 8'h5A});
    serLoad = 1'b1; tick(4);
    modelLoad(2'b10, 1'b1, 8'h5A);
    expectNow("R9 settled");

    // R1 only the last eleven bits count
    shiftBit(1'b1); shiftBit(1'b0); shiftBit(1'b1);
    sendWord(2'b01, 1'b0, 8'h81); pulseLoad(2'b01, 1'b0, 8'h81); expectNow("R1 last 11 bits");

    // R6 held loads, then bulk copy
    setUpd(1'b1);
    sendWord(2'b00, 1'b1, 8'h11); pulseLoad(2'b00, 1'b1, 8'h11); expectNow("R6 held ch0");
    sendWord(2'b11, 1'b0, 8'h77); pulseLoad(2'b11, 1'b0, 8'h77); expectNow("R6 held ch3");
    setUpd(1'b0); expectNow("R6 bulk copy");

    // R2 serial clocks during load low are ignored
    sendWord(2'b10, 1'b1, 8'hC3);
    serLoad = 1'b0; tick(4);
    shiftBit(1'b1); shiftBit(1'b1); shiftBit(1'b1);
    serLoad = 1'b1; tick(4);
    modelLoad(2'b10, 1'b1, 8'hC3);
    expectNow("R2 first load");
    sendWord(2'b10, 1'b1, 8'hC3);
    mOutCode[2] = 8'h00; mInCode[2] = 8'h00;
    // reload the same word after changing ch2 through a fresh word
    sendWord(2'b10, 1'b0, 8'h00); pulseLoad(2'b10, 1'b0, 8'h00); expectNow("R4 ch2 cleared");
    serLoad = 1'b0; tick(4);
    shiftBit(1'b1); shiftBit(1'b0); shiftBit(1'b1);
    serLoad = 1'b1; tick(4);
    modelLoad(2'b10, 1'b0, 8'h00);
    serLoad = 1'b0; tick(4); serLoad = 1'b1; tick(4);
    modelLoad(2'b10, 1'b0, 8'h00);
    expectNow("R2 shift register untouched");

    // R7 reset in the middle of operation
    rstN = 1'b0; tick(2);
    modelReset();
    check({outRange, outCode} === 36'h0, "R7 mid-run reset", {outRange, outCode}, 36'h0);
    rstN = 1'b1; tick(3);
    serLoad = 1'b0; tick(4); serLoad = 1'b1; tick(4);
    modelLoad(2'b00, 1'b0, 8'h00);
    expectNow("R7 shift register cleared");

    tick(6);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule